// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block gathers a parameterised set of level-sensitive interrupt lines (32 by default) and reduces them to two request wires for a processor: an urgent request and a normal request. Each incoming line first passes through a two-stage synchroniser. It is then gated by a per-line enable bit and steered to one of the two request wires by a per-line level bit.

Software uses a small register port to reach three registers. The enable register sets bit = line enabled. The level register sets bit = urgent request. The pending register is read-only and shows the synchronised lines that are currently enabled. The two lowest lines are fixed: line 0 is always enabled and always raises the urgent request. Line 1 is always enabled and always raises the normal request. Reads are combinational. Writes take effect at the clock edge on which they are presented.

Top module: `pic_top`

## Requirements
- R1: After reset, the enable register (address 0) reads 0x00000003 and the level register (address 1) reads 0x00000001. With all inputs low, the pending register (address 2) reads 0 and both request outputs are low.
- R2: Line 0 raises `irq_urgent` and never `irq_normal`. Line 1 raises `irq_normal` and never `irq_urgent`. Both hold whatever value is written to the enable or level register.
- R3: Enable bits 1:0 always read 1,1. Level bit 0 always reads 1 and level bit 1 always reads 0. Writes to these four bits have no effect. All other bits read back as written.
- R4: A line from 2 upward whose enable bit is 0 has no effect on either request output or on the pending register.
- R5: The pending register reads the bitwise AND of the synchronised input levels and the enable register. It is not latched: a bit clears once its input has been low for two clock edges.
- R6: `irq_urgent` is the OR of the enabled synchronised lines whose level bit is 1. `irq_normal` is the OR of the enabled synchronised lines whose level bit is 0.
- R7: A change on an input line reaches the outputs and the pending register on the second rising clock edge after it is applied, and not on the first.
- R8: Writes to address 2 (pending) and address 3 change no register. A read of address 3 returns 0.
- R9: The address map is 0 = enable, 1 = level, 2 = pending. A write to address 0 or 1 shows on the next read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 level, 2 pending, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_lines | input | 32 | Level-sensitive interrupt inputs, asynchronous |
| irq_urgent | output | 1 | Urgent-level request |
| irq_normal | output | 1 | Normal-level request |

## Verification
The assertions assume that the interrupt lines are sampled cleanly into the first synchroniser stage. They also assume at least two clock edges have passed since reset release before any input-to-output relation is checked. A cycle counter in the checker enforces that window. The bench drives the lines and the register port only at falling edges, so every value is stable around the rising edge that captures it. It waits two rising edges after each line change before it samples outputs. The latency test is the one case where it deliberately samples after a single edge.

// File: rtl/pic_pkg.sv
// Package: shared constants and register selector type for the controller.
// Assumes a two-bit register address and at least three interrupt lines.
package pic_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_LEVEL   = 2'd1,
        SEL_PENDING = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    // Bits 1:0 of the enable register are permanently set.
    localparam logic [1:0] FIXED_ENABLE = 2'b11;
    // Line 0 is urgent, line 1 is normal.
    localparam logic [1:0] FIXED_LEVEL  = 2'b01;
endpackage

// File: rtl/pic_sync.sv
// Module: two-flop synchroniser for a bus of independent level signals.
// Assumes each bit is a slow level; no bus coherence is implied.
module pic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pic_regs.sv
// Module: enable and level registers with the two lowest bits fixed.
// Assumes N >= 3; the fixed bits are held constant regardless of writes.
module pic_regs
    import pic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      enable,
    output logic [N-1:0]      level
);
    localparam logic [N-1:0] EN_FORCE_SET = N'(FIXED_ENABLE);
    localparam logic [N-1:0] LV_FORCE_SET = N'(FIXED_LEVEL);
    localparam logic [N-1:0] LV_FORCE_CLR = N'(2'b11);

    logic [N-1:0] en_q;
    logic [N-1:0] lv_q;

    // Update the enable register, forcing its fixed bits high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= EN_FORCE_SET;
        else if (wr && reg_sel_e'(addr) == SEL_ENABLE)
            en_q <= wdata | EN_FORCE_SET;
    end

    // Update the level register, forcing its fixed bits to 0/1 pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lv_q <= LV_FORCE_SET;
        else if (wr && reg_sel_e'(addr) == SEL_LEVEL)
            lv_q <= (wdata & ~LV_FORCE_CLR) | LV_FORCE_SET;
    end

    assign enable = en_q;
    assign level  = lv_q;
endmodule

// File: rtl/pic_route.sv
// Module: gates synchronised lines by enable and splits them by level.
// Assumes inputs already synchronised; purely combinational.
module pic_route #(
    parameter int N = 32
) (
    input  logic [N-1:0] lines,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] level,
    output logic [N-1:0] pending,
    output logic         urgent,
    output logic         normal
);
    logic [N-1:0] live;
    logic [N-1:0] to_urgent;
    logic [N-1:0] to_normal;

    // Per-line split, one slice per line.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign live[i]      = lines[i] & enable[i];
        assign to_urgent[i] = live[i] & level[i];
        assign to_normal[i] = live[i] & ~level[i];
    end

    assign pending = live;
    assign urgent  = |to_urgent;
    assign normal  = |to_normal;
endmodule

// File: rtl/pic_top.sv
// Module: two-level interrupt controller top; register port plus routing.
// Assumes reg_addr/reg_wdata valid while reg_wr is high; reads are combinational.
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_urgent,
    output logic                 irq_normal
);
    logic [NUM_LINES-1:0] synced;
    logic [NUM_LINES-1:0] enable;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] pending;

    pic_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_lines),
        .q     (synced)
    );

    pic_regs #(.N(NUM_LINES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .enable (enable),
        .level  (level)
    );

    pic_route #(.N(NUM_LINES)) u_route (
        .lines   (synced),
        .enable  (enable),
        .level   (level),
        .pending (pending),
        .urgent  (irq_urgent),
        .normal  (irq_normal)
    );

    // Select the register addressed for reading.
    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_ENABLE:  reg_rdata = enable;
            SEL_LEVEL:   reg_rdata = level;
            SEL_PENDING: reg_rdata = pending;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pic_chk.sv
// Module: assertion checker bound to pic_top; observes ports only.
// Assumes inputs are stable around rising edges; waits two edges after reset.
module pic_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   reg_addr,
    input logic [N-1:0] reg_rdata,
    input logic [N-1:0] irq_lines,
    input logic         irq_urgent,
    input logic         irq_normal
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R2 and R7: line 0 high two edges ago must show as urgent.
    a_r2_line0_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(irq_lines[0], 2)) |-> irq_urgent);

    // R2 and R7: line 1 high two edges ago must show as normal.
    a_r2_line1_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(irq_lines[1], 2)) |-> irq_normal);

    // R6: no line high means no request.
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(irq_lines, 2) == '0) |-> (!irq_urgent && !irq_normal));

    // R3: fixed bits of the enable register.
    a_r3_enable_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[1:0] == 2'b11));

    // R3: fixed bits of the level register.
    a_r3_level_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[1:0] == 2'b01));

    // R5: a pending bit needs its input high two edges earlier.
    a_r5_pending_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && reg_addr == 2'd2) |-> ((reg_rdata & ~$past(irq_lines, 2)) == '0));

    // R8: spare address reads zero.
    a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind pic_top pic_chk #(.N(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq_lines  (irq_lines),
    .irq_urgent (irq_urgent),
    .irq_normal (irq_normal)
);

// File: tb/tb_pic_top.sv
// Bench: directed scenarios for pic_top, one task each, self-checking.
module tb_pic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_lines = '0;
    logic        irq_urgent;
    logic        irq_normal;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pic_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_lines  (irq_lines),
        .irq_urgent (irq_urgent),
        .irq_normal (irq_normal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Apply lines at a falling edge, then wait two rising edges.
    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_lines = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 enable reset", d, 32'h3);
        rd(2'd1, d); check("R1 level reset", d, 32'h1);
        rd(2'd2, d); check("R1 pending reset", d, 32'h0);
        check("R1 outputs reset", {30'd0, irq_urgent, irq_normal}, 32'h0);
    endtask

    task automatic t_fixed_lines();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        drive(32'h1);
        check("R2 line0 urgent", {30'd0, irq_urgent, irq_normal}, 32'h2);
        drive(32'h2);
        check("R2 line1 normal", {30'd0, irq_urgent, irq_normal}, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        #1 check("R2 line1 still normal", {30'd0, irq_urgent, irq_normal}, 32'h1);
        drive(32'h0);
    endtask

    task automatic t_fixed_bits();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R3 enable fixed", d, 32'h3);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R3 level fixed hi", d, 32'hFFFF_FFFD);
        wr(2'd1, 32'h0);
        rd(2'd1, d); check("R3 level fixed lo", d, 32'h1);
        wr(2'd0, 32'hA5A5_A5A4);
        rd(2'd0, d); check("R3 enable rw", d, 32'hA5A5_A5A7);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFC);
        drive(32'hFFFF_FFFC);
        check("R4 masked outputs", {30'd0, irq_urgent, irq_normal}, 32'h0);
        rd(2'd2, d); check("R4 masked pending", d, 32'h0);
        drive(32'h0);
    endtask

    task automatic t_route();
        wr(2'd0, 32'h0000_00F0);
        wr(2'd1, 32'h0000_0030);
        drive(32'h0000_0010);
        check("R6 urgent line", {30'd0, irq_urgent, irq_normal}, 32'h2);
        drive(32'h0000_0040);
        check("R6 normal line", {30'd0, irq_urgent, irq_normal}, 32'h1);
        drive(32'h0000_0100);
        check("R6 masked line", {30'd0, irq_urgent, irq_normal}, 32'h0);
        drive(32'h0000_00A0);
        check("R6 both levels", {30'd0, irq_urgent, irq_normal}, 32'h3);
        drive(32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(2'd0, 32'h0000_00F0);
        drive(32'h0000_0333);
        rd(2'd2, d); check("R5 pending and", d, 32'h0000_0033);
        drive(32'h0);
        rd(2'd2, d); check("R5 pending not latched", d, 32'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        irq_lines = 32'h1;
        @(posedge clk);
        @(negedge clk);
        check("R7 after one edge", {31'd0, irq_urgent}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R7 after two edges", {31'd0, irq_urgent}, 32'h1);
        drive(32'h0);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        wr(2'd0, 32'h0000_F000);
        wr(2'd1, 32'h0000_3000);
        rd(2'd0, d); check("R9 enable map", d, 32'h0000_F003);
        rd(2'd1, d); check("R9 level map", d, 32'h0000_3001);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R8 enable kept", d, 32'h0000_F003);
        rd(2'd1, d); check("R8 level kept", d, 32'h0000_3001);
        rd(2'd3, d); check("R8 spare zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_lines();
        t_fixed_bits();
        t_masked();
        t_route();
        t_pending();
        t_latency();
        t_addr();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule